// File: doc/BRIEF.md
# Addressable Programmable Divider Voice Bank

The block is a bank of sixteen tone voices. Each voice is a programmable divider that a controller loads over an address, data and strobe interface. A voice divides its channel's master rate by an integer divisor. It halves its own divided output and ANDs the halved signal with the undivided one. The result is a narrow pulse at the sub-octave rate. Each voice also holds one gate bit, written in the same operation as the divisor, so the tone and its gate start on the same cycle.

The dividers sit in eighteen slots: six groups of three counters. The controller picks a slot with a group select and a counter select. Groups 0 to 2 form channel A and advance on `tick_a_i`. Groups 3 to 5 form channel B and advance on `tick_b_i`, which runs faster to give channel B its shifted footage. The last slot of each channel is unused.

Both master clocks arrive as single-cycle enables in the `clk_i` domain.

Top module: `tone_bank`

## Requirements
- R1: After reset, all bits of `tone_o` and `gate_o` are 0.
- R2: A write addresses slot = 3*grp_i + sel_i. Slots 0..7 map to voices 0..7 (channel A), and slots 9..16 map to voices 8..15 (channel B). Slot 8, slot 17, sel_i = 3 and grp_i >= 6 match no voice, and a write to them changes no output.
- R3: A write with `gate_i` = 1 to a voice whose gate is clear loads the divisor, sets that voice's `gate_o` bit and restarts its phase. For a divisor of 2 or more, `tone_o` is high in the first cycle after the write.
- R4: For divisor n >= 2 with ticks in every cycle, the tone repeats every 2n ticks. It is high for the first floor(n/2) ticks of that cycle and low for the rest, which is 25% duty for even n.
- R5: A write with `gate_i` = 1 to a voice whose gate is already set does not disturb the running period. The new divisor takes effect at the next terminal count, and the sub-octave phase carries on.
- R6: A write with `gate_i` = 0 clears that voice's gate bit. Its tone is low from the next cycle on.
- R7: A divisor of 0 or 1 holds the voice's tone low even while its gate is set.
- R8: A voice's phase advances only in cycles where its channel tick is high. With no tick, its tone holds its level.
- R9: Channel B voices advance on `tick_b_i` independently of `tick_a_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_a_i | input | 1 | Channel A master clock enable |
| tick_b_i | input | 1 | Channel B master clock enable |
| wr_i | input | 1 | Write strobe |
| grp_i | input | 3 | Group select |
| sel_i | input | 2 | Counter select within group |
| div_i | input | 12 | Divisor value |
| gate_i | input | 1 | Gate value written with the divisor |
| tone_o | output | 16 | Pulse tone per voice |
| gate_o | output | 16 | Gate bit per voice |

## Verification
On every cycle the assertions check three things. The address decoder never strobes two voices at once. A voice's phase stays inside its divisor and freezes when no tick arrives. A write to an idle voice, or a gate-clear write, shows up on the tone in the next cycle. Only the bench scenarios can show the tone shape. That covers the high and low run lengths for even and odd divisors, the deferred divisor switch at a period boundary, the fixed slot-to-voice map with its two dead slots, and channel B running while channel A is frozen.

// File: rtl/tone_bank_pkg.sv
package tone_bank_pkg;
  localparam int NUM_CH        = 2;
  localparam int GRP_PER_CH    = 3;
  localparam int CNT_PER_GRP   = 3;
  localparam int SLOTS_PER_CH  = GRP_PER_CH * CNT_PER_GRP;
  localparam int VOICES_PER_CH = SLOTS_PER_CH - 1;
  localparam int NUM_VOICES    = NUM_CH * VOICES_PER_CH;
  localparam int NUM_GRP       = NUM_CH * GRP_PER_CH;
  localparam int GRP_W         = $clog2(NUM_GRP);
  localparam int SEL_W         = $clog2(CNT_PER_GRP + 1);

  // last slot of each channel is left unused
  function automatic int voice_slot(input int v);
    return (v / VOICES_PER_CH) * SLOTS_PER_CH + (v % VOICES_PER_CH);
  endfunction

  function automatic int voice_ch(input int v);
    return v / VOICES_PER_CH;
  endfunction
endpackage

// File: rtl/tone_addr_dec.sv
module tone_addr_dec
  import tone_bank_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [GRP_W-1:0]      grp_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic [NUM_VOICES-1:0] wr_o
);
  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_dec
    localparam int SLOT = voice_slot(v);
    localparam int GRP  = SLOT / CNT_PER_GRP;
    localparam int SEL  = SLOT % CNT_PER_GRP;
    assign wr_o[v] = wr_i && (int'(grp_i) == GRP) && (int'(sel_i) == SEL);
  end

  p_onehot_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_o));
  p_no_wr_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |-> (wr_o == '0));
endmodule

// File: rtl/tone_voice.sv
module tone_voice #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             gate_i,
  output logic             tone_o,
  output logic             gate_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
  localparam logic [DIV_W-1:0] TWO = DIV_W'(2);

  logic [DIV_W-1:0] div_q, pend_q, ph_q;
  logic             pend_v_q, sub_q, gate_q;
  logic             term, start, defer, clr;

  assign term  = (div_q < TWO) || (ph_q == div_q - ONE);
  assign start = wr_i && gate_i && !gate_q;
  assign defer = wr_i && gate_i && gate_q;
  assign clr   = wr_i && !gate_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      ph_q     <= '0;
      sub_q    <= 1'b0;
      gate_q   <= 1'b0;
    end else if (start) begin
      div_q    <= div_i;
      ph_q     <= '0;
      sub_q    <= 1'b1;
      gate_q   <= 1'b1;
      pend_v_q <= 1'b0;
    end else begin
      if (clr) gate_q <= 1'b0;
      if (tick_i) begin
        if (term) begin
          ph_q  <= '0;
          sub_q <= ~sub_q;
          if (defer)                 div_q <= div_i;
          else if (pend_v_q && !clr) div_q <= pend_q;
        end else begin
          ph_q <= ph_q + ONE;
        end
      end
      if (defer) begin
        pend_q   <= div_i;
        pend_v_q <= !(tick_i && term);
      end else if (clr || (tick_i && term)) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  // fundamental high for the first half period, gated by the halved output
  assign tone_o = gate_q && (div_q >= TWO) && sub_q && (ph_q < (div_q >> 1));
  assign gate_o = gate_q;

  p_ph_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q >= TWO) |-> (ph_q < div_q));
  p_hold_no_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> ($stable(ph_q) && $stable(sub_q) && $stable(tone_o)));
  p_start_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && (div_i >= TWO)) |=> (tone_o && gate_o));
  p_clear_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (!tone_o && !gate_o));
  p_small_div_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && (div_i < TWO)) |=> !tone_o);
endmodule

// File: rtl/tone_bank.sv
module tone_bank
  import tone_bank_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_a_i,
  input  logic                  tick_b_i,
  input  logic                  wr_i,
  input  logic [GRP_W-1:0]      grp_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [DIV_W-1:0]      div_i,
  input  logic                  gate_i,
  output logic [NUM_VOICES-1:0] tone_o,
  output logic [NUM_VOICES-1:0] gate_o
);
  logic [NUM_VOICES-1:0] wr_v;
  logic [NUM_CH-1:0]     tick;

  assign tick = {tick_b_i, tick_a_i};

  tone_addr_dec u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .grp_i  (grp_i),
    .sel_i  (sel_i),
    .wr_o   (wr_v)
  );

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
    tone_voice #(.DIV_W(DIV_W)) u_voice (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick[voice_ch(v)]),
      .wr_i   (wr_v[v]),
      .div_i  (div_i),
      .gate_i (gate_i),
      .tone_o (tone_o[v]),
      .gate_o (gate_o[v])
    );
  end
endmodule

// File: tb/tone_bank_tb_top.sv
module tone_bank_tb_top;
  localparam time CLK_P = 10ns;
  localparam int  DW    = 12;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        tick_a = 1'b1, tick_b = 1'b1, wr = 1'b0, gate = 1'b0;
  logic [2:0]  grp = '0;
  logic [1:0]  sel = '0;
  logic [DW-1:0] div = '0;
  logic [15:0] tone_o, gate_o;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { int voice; bit val; string req; } item_t;
  item_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  tone_bank #(.DIV_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_a_i(tick_a), .tick_b_i(tick_b),
    .wr_i(wr), .grp_i(grp), .sel_i(sel), .div_i(div), .gate_i(gate),
    .tone_o(tone_o), .gate_o(gate_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: one expected tone bit per cycle
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(tone_o[it.voice] == it.val, it.req, tone_o[it.voice], it.val);
    end
  end

  task automatic do_write(input int g, input int s, input int d, input bit gt);
    @(negedge clk);
    wr = 1'b1; grp = 3'(g); sel = 2'(s); div = DW'(d); gate = gt;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  // expected pulse from the requirement: high for floor(n/2) ticks of every 2n
  task automatic push_pattern(input int v, input int n, input int ph0, input bit sub0,
                              input int cnt, input string req);
    int ph = ph0;
    bit sb = sub0;
    for (int t = 0; t < cnt; t++) begin
      sb_q.push_back('{v, (n >= 2) && sb && (ph < n / 2), req});
      if (n < 2 || ph == n - 1) begin ph = 0; sb = ~sb; end
      else ph++;
    end
  endtask

  task automatic push_const(input int v, input bit val, input int cnt, input string req);
    for (int t = 0; t < cnt; t++) sb_q.push_back('{v, val, req});
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tone_o == '0, "R1 tone", tone_o, 0);
    chk(gate_o == '0, "R1 gate", gate_o, 0);
    rst_ni = 1'b1;

    // R2: dead addresses
    do_write(2, 2, 4, 1);
    do_write(5, 2, 4, 1);
    do_write(1, 3, 4, 1);
    do_write(6, 0, 4, 1);
    do_write(7, 1, 4, 1);
    @(negedge clk);
    chk(gate_o == '0, "R2 dead slots gate", gate_o, 0);
    chk(tone_o == '0, "R2 dead slots tone", tone_o, 0);
    do_write(2, 1, 4, 1);
    @(negedge clk);
    chk(gate_o == 16'h0080, "R2 slot7 voice7", gate_o, 16'h0080);
    do_write(5, 1, 4, 1);
    @(negedge clk);
    chk(gate_o == 16'h8080, "R2 slot16 voice15", gate_o, 16'h8080);

    // R3/R4 even divisor on voice 0
    do_write(0, 0, 4, 1);
    push_pattern(0, 4, 0, 1, 16, "R3 R4 n4");
    drain();
    // R4 odd divisor on voice 5
    do_write(1, 2, 7, 1);
    push_pattern(5, 7, 0, 1, 28, "R4 n7");
    drain();
    // R9 channel B voice 8
    do_write(3, 0, 6, 1);
    push_pattern(8, 6, 0, 1, 24, "R9 n6 chB");
    drain();

    // R5 deferred divisor change on voice 2
    do_write(0, 2, 4, 1);
    push_pattern(2, 4, 0, 1, 4, "R5 old period");
    do_write(0, 2, 6, 1);
    push_pattern(2, 6, 0, 0, 12, "R5 new period");
    drain();

    // R6 gate clear on running voice 0
    do_write(0, 0, 0, 0);
    push_const(0, 1'b0, 6, "R6 tone low");
    drain();
    chk(gate_o[0] == 1'b0, "R6 gate clear", gate_o[0], 0);

    // R7 small divisors
    do_write(1, 0, 1, 1);
    push_const(3, 1'b0, 8, "R7 n1");
    drain();
    chk(gate_o[3] == 1'b1, "R7 gate set n1", gate_o[3], 1);
    do_write(1, 1, 0, 1);
    push_const(4, 1'b0, 8, "R7 n0");
    drain();

    // R8 channel A frozen, R9 channel B keeps running
    tick_a = 1'b0;
    do_write(0, 1, 4, 1);
    push_const(1, 1'b1, 8, "R8 hold no tick");
    drain();
    do_write(3, 1, 2, 1);
    push_pattern(9, 2, 0, 1, 8, "R9 chB with chA frozen");
    drain();
    tick_a = 1'b1;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule